// File: doc/BRIEF.md
# PLL Settings Register Block with Unlock Sequence

This block holds the settings that steer an on-chip phase-locked loop: an enable, a request to use the loop as the clock source, a multiplier code and a pre-divider code. Software writes reach a set of staging registers first. The active values driven to the PLL change only after software writes the two key bytes to the unlock word in consecutive bus accesses. This guards the clock tree against stray or half-finished writes.

The block also produces the clock-source select. The select is raised only when the committed settings request the connection with the loop enabled, and the loop reports lock. Loss of lock afterwards does not drop the select. Only a committed change of the settings releases it.

The bus is a plain synchronous register port. A write or read takes one cycle. Read data is combinational from the address in the same cycle. No valid/ready handshake exists, because every access completes at once and there is no back-pressure. The PLL-side pins are plain level signals.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, pll_en, pll_conn, pll_sel, pll_mult and pll_prediv are 0, and reads of words 0, 1 and 3 return 0.
- R2: Word 0 is the control stage: bit 0 is enable and bit 1 is connect. A read returns the written (staged) bits. Bits 31:2 read as 0, and writing them has no effect.
- R3: Word 1 is the configuration stage: bits 14:0 hold the multiplier code (M-1) and bits 23:16 hold the pre-divider code (N-1). No range checking is applied. A read returns the staged fields, and all other bits read as 0.
- R4: A write to word 0 or word 1 does not change pll_en, pll_conn, pll_mult, pll_prediv or the status word until an unlock sequence completes.
- R5: Unlock sequence: a write with low byte 0xAA to word 2, then a write with low byte 0x55 to word 2 as the next bus access. Idle cycles between the two are allowed. The active outputs show the staged values from the cycle after the 0x55 write.
- R6: Any read, any write to another word, or a wrong value between or in place of the two key writes cancels the sequence. A fresh 0xAA is then needed, and the active outputs keep their values.
- R7: Word 3 is status: bits 14:0 active multiplier, bits 23:16 active pre-divider, bit 24 active enable, bit 25 pll_conn, bit 26 current pll_lock, and all other bits 0. Word 2 reads as 0.
- R8: pll_conn equals the committed connect bit ANDed with the committed enable bit.
- R9: pll_sel rises one cycle after pll_conn and pll_lock are both 1, and never without them.
- R10: pll_sel stays 1 when pll_lock falls while pll_conn is 1. It clears one cycle after pll_conn goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (counts as an access for the unlock sequence) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_en | output | 1 | Active enable |
| pll_conn | output | 1 | Active connect request, qualified by enable |
| pll_mult | output | 15 | Active multiplier code (M-1) |
| pll_prediv | output | 8 | Active pre-divider code (N-1) |
| pll_sel | output | 1 | Select the PLL as clock source |

## Verification
If the unlock tracker is armed when it should not be, a lone 0x55 write commits the staged settings. The stray commit shows on the active outputs and in the status word one cycle later. A staging register that is mixed up with an active one shows at once on reads: words 0 and 1 then disagree with word 3. If the source-select state is wrong, pll_sel moves on the edge after lock changes, either rising without lock or falling on lock loss. The bench detects this within a single cycle.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
  localparam int BUS_AW = 2;
  localparam int BUS_DW = 32;
  localparam int MUL_W  = 15;
  localparam int DIV_W  = 8;
  localparam int DIV_LSB = 16;
  localparam int ST_EN   = 24;
  localparam int ST_CONN = 25;
  localparam int ST_LOCK = 26;

  localparam logic [BUS_AW-1:0] A_CTRL = 2'd0;
  localparam logic [BUS_AW-1:0] A_CFG  = 2'd1;
  localparam logic [BUS_AW-1:0] A_KEY  = 2'd2;
  localparam logic [BUS_AW-1:0] A_STAT = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef struct packed {
    logic             en;
    logic             conn;
    logic [MUL_W-1:0] mul;
    logic [DIV_W-1:0] div;
  } pll_set_t;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_feed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        key,
  output logic              commit
);
  logic armed_q;
  logic key_hit;

  assign key_hit = wr && (addr == A_KEY);
  assign commit  = armed_q && key_hit && (key == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (wr || rd) armed_q <= key_hit && (key == KEY_FIRST);
  end

  // R6
  abort_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !armed_q);
endmodule

// File: rtl/pll_set_stage.sv
module pll_set_stage
  import pll_feed_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  logic     wr_cfg,
  input  pll_set_t wr_val,
  input  logic     commit,
  output pll_set_t stage,
  output pll_set_t act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
      act   <= '0;
    end else begin
      if (wr_ctrl) begin
        stage.en   <= wr_val.en;
        stage.conn <= wr_val.conn;
      end
      if (wr_cfg) begin
        stage.mul <= wr_val.mul;
        stage.div <= wr_val.div;
      end
      if (commit) act <= stage;
    end
  end

  // R4
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act));
  // R5
  commit_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act == $past(stage)));
endmodule

// File: rtl/pll_src_gate.sv
module pll_src_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_req,
  input  logic lock,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) sel <= 1'b0;
    else        sel <= conn_req && (sel || lock);
  end

  // R9
  rise_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(conn_req && lock));
  // R10
  keep_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && conn_req && !lock) |=> sel);
  // R10
  drop_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conn_req |=> !sel);
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pll_feed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              pll_lock,
  output logic              pll_en,
  output logic              pll_conn,
  output logic [MUL_W-1:0]  pll_mult,
  output logic [DIV_W-1:0]  pll_prediv,
  output logic              pll_sel
);
  pll_set_t wr_val, stage, act;
  logic commit, wr_ctrl, wr_cfg;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata[BUS_DW-1:DIV_LSB+DIV_W], bus_wdata[DIV_LSB-1]};
  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == A_CFG);
  assign wr_val  = '{en:   bus_wdata[0],
                     conn: bus_wdata[1],
                     mul:  bus_wdata[MUL_W-1:0],
                     div:  bus_wdata[DIV_LSB +: DIV_W]};

  pll_feed_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_we), .rd(bus_re),
    .addr(bus_addr), .key(bus_wdata[7:0]), .commit(commit)
  );

  pll_set_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
    .wr_val(wr_val), .commit(commit), .stage(stage), .act(act)
  );

  assign pll_en     = act.en;
  assign pll_conn   = act.conn && act.en;
  assign pll_mult   = act.mul;
  assign pll_prediv = act.div;

  pll_src_gate u_gate (
    .clk(clk), .rst_n(rst_n), .conn_req(pll_conn), .lock(pll_lock), .sel(pll_sel)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = stage.en;
        bus_rdata[1] = stage.conn;
      end
      A_CFG: begin
        bus_rdata[MUL_W-1:0]         = stage.mul;
        bus_rdata[DIV_LSB +: DIV_W]  = stage.div;
      end
      A_STAT: begin
        bus_rdata[MUL_W-1:0]         = act.mul;
        bus_rdata[DIV_LSB +: DIV_W]  = act.div;
        bus_rdata[ST_EN]             = pll_en;
        bus_rdata[ST_CONN]           = pll_conn;
        bus_rdata[ST_LOCK]           = pll_lock;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R8
  conn_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_conn |-> pll_en);
endmodule

// File: tb/test_pll_feed_regs.sv
module test_pll_feed_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_lock = 1'b0;
  logic        pll_en, pll_conn, pll_sel;
  logic [14:0] pll_mult;
  logic [7:0]  pll_prediv;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_feed_regs i_pll_feed_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
    .pll_en(pll_en), .pll_conn(pll_conn), .pll_mult(pll_mult),
    .pll_prediv(pll_prediv), .pll_sel(pll_sel)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as reads happen
  always @(negedge clk) begin
    cycles++;
    if (rst_n && bus_re) begin
      if (exp_q.size() == 0) chk("read-without-expectation", bus_rdata, 32'hx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  function automatic logic [31:0] stat(logic [14:0] m, logic [7:0] n,
                                       logic e, logic c, logic l);
    return {5'b0, l, c, e, n, 1'b0, m};
  endfunction

  task automatic unlock();
    wr(2'd2, 32'h0000_00AA);
    wr(2'd2, 32'h0000_0055);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    chk("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 outputs", {pll_en, pll_conn, pll_sel, pll_mult, pll_prediv}, '0);
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 cfg");
    rd(2'd3, 32'h0, "R1 status");

    // R2 / R3 staging with reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_0003, "R2 ctrl staged, reserved zero");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h00FF_7FFF, "R3 cfg staged, reserved zero");
    // R4 nothing active yet
    chk("R4 outputs untouched", {pll_en, pll_conn, pll_mult, pll_prediv}, '0);
    rd(2'd3, 32'h0, "R4 status untouched");

    wr(2'd1, 32'h0001_0063);
    wr(2'd0, 32'h0000_0001);
    rd(2'd1, 32'h0001_0063, "R3 cfg readback");

    // R6 aborts
    wr(2'd2, 32'h0000_00AA);
    rd(2'd0, 32'h0000_0001, "R2 ctrl read during abort");
    wr(2'd2, 32'h0000_0055);
    chk("R6 read aborts", {pll_en, pll_mult}, '0);
    wr(2'd2, 32'h0000_00AA);
    wr(2'd2, 32'h0000_0056);
    wr(2'd2, 32'h0000_0055);
    chk("R6 wrong key aborts", {pll_en, pll_mult}, '0);
    wr(2'd2, 32'h0000_00AA);
    wr(2'd1, 32'h0001_0063);
    wr(2'd2, 32'h0000_0055);
    chk("R6 other write aborts", {pll_en, pll_mult}, '0);
    rd(2'd2, 32'h0, "R7 key word reads zero");

    // R5 commit with idle gap
    wr(2'd2, 32'h0000_00AA);
    idle(2);
    wr(2'd2, 32'h0000_0055);
    chk("R5 enable active", pll_en, 1);
    chk("R5 mult active", pll_mult, 15'h63);
    chk("R5 prediv active", pll_prediv, 8'h01);
    chk("R8 conn without request", pll_conn, 0);
    rd(2'd3, stat(15'h63, 8'h01, 1, 0, 0), "R7 status after commit");

    // R8 / R9 connect
    wr(2'd0, 32'h0000_0003);
    chk("R4 conn staged only", pll_conn, 0);
    unlock();
    chk("R8 conn committed", pll_conn, 1);
    idle(2);
    chk("R9 no select without lock", pll_sel, 0);
    pll_lock = 1'b1;
    idle(1);
    chk("R9 select after lock", pll_sel, 1);
    rd(2'd3, stat(15'h63, 8'h01, 1, 1, 1), "R7 status with lock");

    // R10 lock loss keeps select
    pll_lock = 1'b0;
    idle(4);
    chk("R10 select held on lock loss", pll_sel, 1);

    // R8 / R10 disable releases
    wr(2'd0, 32'h0000_0002);
    unlock();
    chk("R8 conn forced off", {pll_en, pll_conn}, 2'b00);
    chk("R10 select one more cycle", pll_sel, 1);
    idle(1);
    chk("R10 select released", pll_sel, 0);
    rd(2'd0, 32'h0000_0002, "R2 staged connect kept");

    idle(2);
    finish_run();
  end
endmodule